// File: doc/BRIEF.md
# TDM Signalling-Channel Byte Accumulator

This block attaches to a 2.048 Mb/s time-division serial highway carrying 32 eight-bit channels per 125 µs frame, marked by a frame pulse. Channel 0 carries the low-rate signalling (D) channel. At 16 kb/s, two D bits are taken from the start of channel 0 in each frame. At 8 kb/s, one bit is taken. Received bits are packed into a byte that a host processor reads over a simple register port. In the other direction, a byte the host writes is spread out over the D positions of the following frames. Channels 1 to 31 are neither sampled nor driven.

A byte boundary falls every fourth frame at 16 kb/s and every eighth frame at 8 kb/s. At each boundary the block raises an interrupt, and the host services it with a read, a write or both. If the host writes nothing, the last written byte is sent again for each later byte period. When the enable control is low, the serial output and the interrupt float, but received data is still packed. One clock cycle of `clk` is one bit period of the highway.

Top module: `tdm_dch_accum`

## Requirements
- R1: The cycle with `frame_sync` high is bit position 0 of a 256-bit frame. D bits occupy position 0 and, at 16 kb/s, position 1. `ser_out_en` is never high at any other position, and no D slot exists before the first frame pulse after reset.
- R2: At 16 kb/s (`cfg_rate8`=0), the four frames of a byte period fill the read byte two bits at a time. The first frame goes to bits 1:0 (position 0 into the lower bit) and the fourth frame goes to bits 7:6. `rd_data` shows the new byte from the cycle after the last D bit of the fourth frame.
- R3: At 8 kb/s (`cfg_rate8`=1), one bit per frame is taken at position 0, filling bit 0 first. A byte completes every eighth frame, and `ser_out_en` stays low at position 1.
- R4: A byte written (`acc_sel`=1, `acc_wr`=1) during the last frame of a byte period, after its D slot, is sent in the next byte period. Bit 0 goes out first: bits 1:0 in the first following frame, up to bits 7:6 in the fourth frame at 16 kb/s.
- R5: When nothing is written during a byte period, the next byte period sends the same byte again.
- R6: The transmit byte is all ones after `rst_n` and after a `soft_rst` pulse.
- R7: With `cfg_enable`=0, `ser_out_en` and `irq_oe` are low, but received bytes still reach `rd_data`.
- R8: `irq` rises in the cycle after the last D bit of each byte period. A register access of either kind (`acc_sel`=1) clears it in the next cycle.
- R9: `soft_rst` clears `irq` and restarts byte alignment, so the next D slot carries bit 0 of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per highway bit |
| rst_n | input | 1 | Active-low power-up reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| frame_sync | input | 1 | High during bit 0 of each frame |
| ser_in | input | 1 | Receive serial data |
| ser_out | output | 1 | Transmit serial data, valid when enabled |
| ser_out_en | output | 1 | Output driver enable (low = high impedance) |
| cfg_enable | input | 1 | 1: transmit and interrupt active; 0: receive only |
| cfg_rate8 | input | 1 | 1: 8 kb/s, 0: 16 kb/s |
| acc_sel | input | 1 | Register access strobe, one cycle |
| acc_wr | input | 1 | 1: write, 0: read |
| acc_wdata | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last complete received byte |
| irq | output | 1 | Byte-boundary interrupt |
| irq_oe | output | 1 | Interrupt driver enable |

## Verification
The assertions assume that `frame_sync` arrives every 256 cycles and that `cfg_rate8` changes only at a byte boundary. The bench therefore generates frames back to back with no extra cycles, and it changes the rate only between whole byte periods. Host accesses and soft resets come at bit position 100 of the last frame of a period, which is well clear of any D slot. Because of this, the check that an access clears `irq` never competes with a boundary in the same cycle.

// File: rtl/tdm_dch_pkg.sv
package tdm_dch_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e decode_access(input logic sel, input logic wr);
        if (!sel)    return ACC_IDLE;
        else if (wr) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

endpackage

// File: rtl/tdm_dch_timer.sv
module tdm_dch_timer #(
    parameter int FRAME_BITS = 256,
    parameter int BYTE_BITS  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          frame_sync,
    input  logic                          rate8,
    output logic [$clog2(FRAME_BITS)-1:0] slot_pos,
    output logic                          dbit_valid,
    output logic [$clog2(BYTE_BITS)-1:0]  dbit_idx,
    output logic                          byte_first,
    output logic                          byte_last
);
    localparam int PW = $clog2(FRAME_BITS);
    localparam int IW = $clog2(BYTE_BITS);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          synced;
        logic [IW-1:0] idx;
    } tmr_t;

    tmr_t st_q, st_d;
    logic [PW-1:0] pos;
    logic          in_dslot;

    always_comb begin
        st_d     = st_q;
        pos      = frame_sync ? '0 : st_q.cnt;
        st_d.cnt = (pos == PW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
        st_d.synced = st_q.synced | frame_sync;
        in_dslot = (st_q.synced | frame_sync) &&
                   ((pos == '0) || ((pos == PW'(1)) && !rate8));
        if (in_dslot) begin
            st_d.idx = (st_q.idx == IW'(BYTE_BITS - 1)) ? '0 : st_q.idx + 1'b1;
        end
        if (soft_rst) begin
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_pos   = pos;
    assign dbit_valid = in_dslot;
    assign dbit_idx   = st_q.idx;
    assign byte_first = in_dslot && (st_q.idx == '0);
    assign byte_last  = in_dslot && (st_q.idx == IW'(BYTE_BITS - 1));
endmodule

// File: rtl/tdm_dch_rx.sv
module tdm_dch_rx #(
    parameter int BYTE_BITS = 8
) (
    input  logic                         clk,
    input  logic                         dbit_valid,
    input  logic [$clog2(BYTE_BITS)-1:0] dbit_idx,
    input  logic                         byte_last,
    input  logic                         ser_in,
    output logic [BYTE_BITS-1:0]         rd_byte
);
    typedef struct packed {
        logic [BYTE_BITS-1:0] acc;
        logic [BYTE_BITS-1:0] rd;
    } rx_t;

    rx_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (dbit_valid) begin
            st_d.acc[dbit_idx] = ser_in;
        end
        if (byte_last) begin
            st_d.rd = st_d.acc;
        end
    end

    // Receive storage has no defined reset value.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_byte = st_q.rd;
endmodule

// File: rtl/tdm_dch_tx.sv
module tdm_dch_tx #(
    parameter int BYTE_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst,
    input  logic                         wr_en,
    input  logic [BYTE_BITS-1:0]         wr_data,
    input  logic                         dbit_valid,
    input  logic [$clog2(BYTE_BITS)-1:0] dbit_idx,
    input  logic                         byte_first,
    output logic                         tx_bit
);
    typedef struct packed {
        logic [BYTE_BITS-1:0] hold;
        logic [BYTE_BITS-1:0] cur;
    } tx_t;

    tx_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        tx_bit = byte_first ? st_q.hold[0] : st_q.cur[dbit_idx];
        if (dbit_valid && byte_first) begin
            st_d.cur = st_q.hold;
        end
        if (wr_en) begin
            st_d.hold = wr_data;
        end
        if (soft_rst) begin
            st_d.hold = '1;
            st_d.cur  = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hold: '1, cur: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tdm_dch_accum.sv
module tdm_dch_accum #(
    parameter int FRAME_BITS = 256,
    parameter int BYTE_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 frame_sync,
    input  logic                 ser_in,
    output logic                 ser_out,
    output logic                 ser_out_en,
    input  logic                 cfg_enable,
    input  logic                 cfg_rate8,
    input  logic                 acc_sel,
    input  logic                 acc_wr,
    input  logic [BYTE_BITS-1:0] acc_wdata,
    output logic [BYTE_BITS-1:0] rd_data,
    output logic                 irq,
    output logic                 irq_oe
);
    import tdm_dch_pkg::*;

    localparam int PW = $clog2(FRAME_BITS);
    localparam int IW = $clog2(BYTE_BITS);

    logic [PW-1:0] slot_pos;
    logic          dbit_valid;
    logic [IW-1:0] dbit_idx;
    logic          byte_first;
    logic          byte_last;
    logic          tx_bit;
    acc_kind_e     acc_kind;

    typedef struct packed {
        logic irq;
    } top_t;

    top_t st_q, st_d;

    tdm_dch_timer #(.FRAME_BITS(FRAME_BITS), .BYTE_BITS(BYTE_BITS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .frame_sync (frame_sync),
        .rate8      (cfg_rate8),
        .slot_pos   (slot_pos),
        .dbit_valid (dbit_valid),
        .dbit_idx   (dbit_idx),
        .byte_first (byte_first),
        .byte_last  (byte_last)
    );

    tdm_dch_rx #(.BYTE_BITS(BYTE_BITS)) u_rx (
        .clk        (clk),
        .dbit_valid (dbit_valid),
        .dbit_idx   (dbit_idx),
        .byte_last  (byte_last),
        .ser_in     (ser_in),
        .rd_byte    (rd_data)
    );

    tdm_dch_tx #(.BYTE_BITS(BYTE_BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_en      (acc_kind == ACC_WRITE),
        .wr_data    (acc_wdata),
        .dbit_valid (dbit_valid),
        .dbit_idx   (dbit_idx),
        .byte_first (byte_first),
        .tx_bit     (tx_bit)
    );

    always_comb begin
        acc_kind = decode_access(acc_sel, acc_wr);
        st_d     = st_q;
        if (acc_kind != ACC_IDLE) st_d.irq = 1'b0;
        if (byte_last)            st_d.irq = 1'b1;
        if (soft_rst)             st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out_en = cfg_enable && dbit_valid;
    assign ser_out    = ser_out_en ? tx_bit : 1'b0;
    assign irq        = st_q.irq;
    assign irq_oe     = cfg_enable;
endmodule

// File: rtl/tdm_dch_accum_chk.sv
module tdm_dch_accum_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          cfg_enable,
    input logic          cfg_rate8,
    input logic          acc_sel,
    input logic          ser_out_en,
    input logic          irq,
    input logic [PW-1:0] slot_pos,
    input logic          dbit_valid,
    input logic          byte_last
);
    assert_oe_in_dslot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_en |-> (slot_pos < PW'(2)));

    assert_oe_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_en |-> cfg_enable);

    assert_slow_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rate8 && slot_pos == PW'(1)) |-> !ser_out_en);

    assert_irq_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dbit_valid && byte_last));

    assert_irq_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && !byte_last) |=> !irq);

    assert_soft_clears_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq);
endmodule

bind tdm_dch_accum tdm_dch_accum_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cfg_enable (cfg_enable),
    .cfg_rate8  (cfg_rate8),
    .acc_sel    (acc_sel),
    .ser_out_en (ser_out_en),
    .irq        (irq),
    .slot_pos   (slot_pos),
    .dbit_valid (dbit_valid),
    .byte_last  (byte_last)
);

// File: tb/tdm_dch_accum_bench.sv
`timescale 1ns/1ps
module tdm_dch_accum_bench;
    localparam int ACT_NONE  = 0;
    localparam int ACT_READ  = 1;
    localparam int ACT_WRITE = 2;
    localparam int ACT_SOFT  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       frame_sync = 1'b0;
    logic       ser_in = 1'b0;
    logic       ser_out, ser_out_en;
    logic       cfg_enable = 1'b0;
    logic       cfg_rate8 = 1'b0;
    logic       acc_sel = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       irq, irq_oe;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tdm_dch_accum u_tdm_dch_accum (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_sync(frame_sync),
        .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en),
        .cfg_enable(cfg_enable), .cfg_rate8(cfg_rate8), .acc_sel(acc_sel),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .irq(irq), .irq_oe(irq_oe)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One 256-bit frame; nbits D bits at positions 0..nbits-1.
    task automatic do_frame(input logic [1:0] rxb, input logic [1:0] txe, input int nbits,
                            input logic last, input int act, input logic [7:0] wd,
                            input logic [7:0] exp_rd);
        logic stray;
        stray = 1'b0;
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            frame_sync = (p == 0);
            ser_in     = (p < nbits) ? rxb[p] : 1'b0;
            acc_sel    = 1'b0;
            soft_rst   = 1'b0;
            if (last && p == 100) begin
                acc_sel   = (act == ACT_READ) || (act == ACT_WRITE);
                acc_wr    = (act == ACT_WRITE);
                acc_wdata = wd;
                soft_rst  = (act == ACT_SOFT);
            end
            #5;
            if (p < nbits) begin
                check(ser_out_en == cfg_enable, "R7 D-slot output enable", ser_out_en, cfg_enable);
                if (cfg_enable)
                    check(ser_out == txe[p], "R4/R5/R6 transmitted D bit", ser_out, txe[p]);
            end else if (ser_out_en) begin
                stray = 1'b1;
            end
            if (last && p == 100) begin
                check(irq_oe == cfg_enable, "R7 interrupt enable", irq_oe, cfg_enable);
                check(irq == 1'b1, "R8 interrupt at byte boundary", irq, 1);
                check(rd_data == exp_rd, cfg_rate8 ? "R3 received byte" : "R2 received byte",
                      rd_data, exp_rd);
            end
            if (last && p == 101 && act != ACT_NONE)
                check(irq == 1'b0, act == ACT_SOFT ? "R9 soft reset clears irq" : "R8 access clears irq",
                      irq, 0);
        end
        check(!stray, "R1 output enable outside D slot", stray, 0);
    endtask

    task automatic xfer_byte(input logic [7:0] rx, input logic [7:0] exp_tx,
                             input int act, input logic [7:0] wd);
        int bpf, nf;
        logic [7:0] rs, ts;
        bpf = cfg_rate8 ? 1 : 2;
        nf  = 8 / bpf;
        for (int f = 0; f < nf; f++) begin
            rs = rx >> (f * bpf);
            ts = exp_tx >> (f * bpf);
            do_frame(rs[1:0], ts[1:0], bpf, f == nf - 1, act, wd, rx);
        end
    endtask

    initial begin
        #(20.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] prev, nxt, rxv;
        repeat (4) @(negedge clk);
        #5;
        check(ser_out_en == 1'b0, "R1 reset output enable", ser_out_en, 0);
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        check(irq_oe == 1'b0, "R7 reset irq enable", irq_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #5;
        check(ser_out_en == 1'b0, "R1 no D slot before frame pulse", ser_out_en, 0);

        // R7: disabled, receive continues
        cfg_enable = 1'b0;
        xfer_byte(8'hA5, 8'hFF, ACT_READ, 8'h00);
        xfer_byte(8'h3E, 8'hFF, ACT_NONE, 8'h00);

        // R6 power-up value, R4 write, R5 resend
        cfg_enable = 1'b1;
        xfer_byte(8'h5A, 8'hFF, ACT_WRITE, 8'h3C);
        xfer_byte(8'hC3, 8'h3C, ACT_NONE, 8'h00);
        xfer_byte(8'h96, 8'h3C, ACT_READ, 8'h00);

        // R2/R4 sweep of patterns at 16 kb/s
        prev = 8'h3C;
        for (int i = 0; i < 8; i++) begin
            nxt = 8'(i * 37 + 11);
            rxv = 8'(i * 73 + 5);
            xfer_byte(rxv, prev, ACT_WRITE, nxt);
            prev = nxt;
        end

        // R3 8 kb/s
        cfg_rate8 = 1'b1;
        xfer_byte(8'h6B, prev, ACT_WRITE, 8'h81);
        xfer_byte(8'hD2, 8'h81, ACT_SOFT, 8'h00);
        // R6/R9 after soft reset
        xfer_byte(8'h0F, 8'hFF, ACT_READ, 8'h00);
        xfer_byte(8'h4D, 8'hFF, ACT_WRITE, 8'hE7);
        cfg_rate8 = 1'b0;
        xfer_byte(8'hF0, 8'hE7, ACT_WRITE, 8'h55);
        xfer_byte(8'h11, 8'h55, ACT_READ, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule